// File: doc/BRIEF.md
# Full-Duplex Serial Command Decoder

This block is a serial slave on a four-wire synchronous link: active-low chip select, bit clock, data in and data out. It puts the incoming bits together into one-byte commands and sorts each byte into one of five kinds: an instruction, a filler (sync) byte, a register write, a register read, or an ignored byte. Instructions leave the block as a one-cycle strobe that carries the opcode. A register write waits for three data bytes and then issues a single strobe that carries the address and the 24-bit value. A register read asks the surrounding register file for a value one cycle after its request strobe. It then shifts that value out on data out while the host keeps clocking in further bytes.

The link is full duplex. The decoder keeps working on incoming bytes while read data is still leaving the block. Instructions and filler bytes leave an ongoing read alone. A new read command replaces the read in progress. The serial pins are oversampled in the system clock domain through synchronizers. For that reason, each half period of the bit clock must last at least six system clock cycles.

Top module: `spi_cmd_decoder`

## Requirements
- R1: While chip select is low, data in is sampled on each rising edge of the bit clock, most significant bit first. Every eight samples form one byte.
- R2: A byte with bit 7 = 1, other than 0xFF and 0xFE, produces a one-cycle `instr_valid_o` pulse with the byte on `instr_op_o`. It does not change the read data leaving on data out.
- R3: A byte of the form 01AAAAA0 (bits 5:1 = address) starts a write. After exactly three further bytes, `wr_valid_o` pulses once, with the address on `wr_addr_o` and the data on `wr_data_o`, where the first data byte is bits 23:16. No write strobe appears before the third data byte.
- R4: A byte of the form 00AAAAA0 produces a one-cycle `rd_req_o` pulse with address bits 5:1 on `rd_addr_o`. `rd_data_i` is taken on the clock cycle after the pulse.
- R5: Read data leaves on data out most significant bit first. The first bit appears after the first falling edge that follows the eighth rising edge of the read command. After 24 bits, data out is 0. Data out is 0 when no read is active.
- R6: Data out changes only after a falling edge of the bit clock, or when chip select is released.
- R7: Outside a write, the bytes 0xFF and 0xFE produce no strobe and do not disturb read data that is shifting out.
- R8: A read command received while read data is still shifting out ends that read. The bits that follow come from the new register, starting at bit 23.
- R9: Releasing chip select discards any partial byte, abandons a write that is collecting data, and stops read output (data out 0). The next full byte is decoded as a command.
- R10: A byte with bit 7 = 0 and bit 0 = 1 is ignored: no strobe, and read output continues.
- R11: During the three data bytes of a write, every value is taken as data, including 0xFF, 0xFE and values with bit 7 set.
- R12: At most one of the instruction, write and read strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| instr_valid_o | output | 1 | Instruction strobe |
| instr_op_o | output | 8 | Instruction opcode |
| wr_valid_o | output | 1 | Register write strobe |
| wr_addr_o | output | 5 | Register write address |
| wr_data_o | output | 24 | Register write data |
| rd_req_o | output | 1 | Register read request strobe |
| rd_addr_o | output | 5 | Register read address |
| rd_data_i | input | 24 | Read value, valid the cycle after `rd_req_o` |

## Verification
Suppose the bit counter slips, or a partial byte survives a chip-select release. Every later byte is then misaligned. The next command comes out as the wrong strobe, or as no strobe, within one byte time. Suppose instead the parser stays stuck in, or leaves too early, the write data phase. The scoreboard then sees a wrong address, wrong data or an unexpected instruction at the end of that write. Errors in read loading or in abort handling show up in the very next byte sampled from data out, because each register's value is distinct and the bench compares it bit for bit.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    CK_NOP,
    CK_SYNC,
    CK_INSTR,
    CK_WRITE,
    CK_READ
  } cmd_kind_e;

  localparam logic [7:0] FILL_HI = 8'hFF;
  localparam logic [7:0] FILL_LO = 8'hFE;

  function automatic cmd_kind_e classify(input logic [7:0] b);
    if (b == FILL_HI || b == FILL_LO) return CK_SYNC;
    if (b[7]) return CK_INSTR;
    if (b[0]) return CK_NOP;
    return b[6] ? CK_WRITE : CK_READ;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_act_o,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);

  logic [STAGES-1:0] sclk_q, cs_q, sdi_q;
  logic              sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_ni};
      sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign cs_act_o = ~cs_q[STAGES-1];
  assign rise_o   = cs_act_o &  sclk_q[STAGES-1] & ~sclk_d;
  assign fall_o   = cs_act_o & ~sclk_q[STAGES-1] &  sclk_d;
  assign sdi_o    = sdi_q[STAGES-1];

endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_act_i,
  input  logic       rise_i,
  input  logic       sdi_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o
);

  logic [2:0] cnt_q;
  logic [6:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      sr_q         <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else if (!cs_act_i) begin
      cnt_q        <= '0;
      sr_q         <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (rise_i) begin
        if (cnt_q == 3'd7) begin
          byte_o       <= {sr_q, sdi_i};
          byte_valid_o <= 1'b1;
          sr_q         <= '0;
          cnt_q        <= '0;
        end else begin
          sr_q  <= {sr_q[5:0], sdi_i};
          cnt_q <= cnt_q + 3'd1;
        end
      end
    end
  end

  a_r1_byte_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(rise_i));
  a_r9_byte_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(cs_act_i));

endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_BYTES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_act_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  output logic                    instr_valid_o,
  output logic [7:0]              instr_op_o,
  output logic                    wr_valid_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [DATA_BYTES*8-1:0] wr_data_o,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o
);

  localparam int DATA_W = DATA_BYTES * 8;
  localparam int BCNT_W = $clog2(DATA_BYTES + 1);
  localparam logic [BCNT_W-1:0] LAST_BYTE = BCNT_W'(DATA_BYTES - 1);

  typedef enum logic {ST_CMD, ST_DATA} state_e;

  state_e            state_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_next;

  assign acc_next = {acc_q[DATA_W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_CMD;
      bcnt_q        <= '0;
      acc_q         <= '0;
      instr_valid_o <= 1'b0;
      instr_op_o    <= '0;
      wr_valid_o    <= 1'b0;
      wr_addr_o     <= '0;
      wr_data_o     <= '0;
      rd_req_o      <= 1'b0;
      rd_addr_o     <= '0;
    end else begin
      instr_valid_o <= 1'b0;
      wr_valid_o    <= 1'b0;
      rd_req_o      <= 1'b0;
      if (!cs_act_i) begin
        state_q <= ST_CMD;
        bcnt_q  <= '0;
      end else if (byte_valid_i) begin
        case (state_q)
          ST_CMD: begin
            case (classify(byte_i))
              CK_INSTR: begin
                instr_valid_o <= 1'b1;
                instr_op_o    <= byte_i;
              end
              CK_WRITE: begin
                wr_addr_o <= byte_i[ADDR_W:1];
                bcnt_q    <= '0;
                state_q   <= ST_DATA;
              end
              CK_READ: begin
                rd_req_o  <= 1'b1;
                rd_addr_o <= byte_i[ADDR_W:1];
              end
              default: ;
            endcase
          end
          ST_DATA: begin
            acc_q <= acc_next;
            if (bcnt_q == LAST_BYTE) begin
              wr_valid_o <= 1'b1;
              wr_data_o  <= acc_next;
              bcnt_q     <= '0;
              state_q    <= ST_CMD;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end
    end
  end

  a_r3_write_from_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($past(state_q) == ST_DATA && $past(byte_valid_i)));
  a_r4_read_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r2_instr_from_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> ($past(state_q) == ST_CMD && instr_op_o[7]));
  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({instr_valid_o, wr_valid_o, rd_req_o}));

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              fall_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o
);

  localparam int LEFT_W = $clog2(DATA_W + 1);

  logic              load_q;
  logic [DATA_W-1:0] sr_q;
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      sr_q   <= '0;
      left_q <= '0;
      sdo_o  <= 1'b0;
    end else if (!cs_act_i) begin
      load_q <= 1'b0;
      sr_q   <= '0;
      left_q <= '0;
      sdo_o  <= 1'b0;
    end else begin
      load_q <= rd_req_i;
      if (load_q) begin
        // new read replaces any read in progress
        sr_q   <= rd_data_i;
        left_q <= LEFT_W'(DATA_W);
      end else if (fall_i) begin
        if (left_q != '0) begin
          sdo_o  <= sr_q[DATA_W-1];
          sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
          left_q <= left_q - 1'b1;
        end else begin
          sdo_o <= 1'b0;
        end
      end
    end
  end

  a_r6_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(fall_i) || !$past(cs_act_i)));
  a_r5_load_clear_of_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> !fall_i);

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int ADDR_W      = 5,
  parameter int DATA_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  output logic                    instr_valid_o,
  output logic [7:0]              instr_op_o,
  output logic                    wr_valid_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [DATA_BYTES*8-1:0] wr_data_o,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic [DATA_BYTES*8-1:0] rd_data_i
);

  localparam int DATA_W = DATA_BYTES * 8;

  logic       cs_act, rise, fall, sdi_s;
  logic       byte_valid;
  logic [7:0] rx_byte;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sclk_i  (sclk_i),
    .sdi_i   (sdi_i),
    .cs_act_o(cs_act),
    .rise_o  (rise),
    .fall_o  (fall),
    .sdi_o   (sdi_s)
  );

  spi_rx_shifter i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .rise_i      (rise),
    .sdi_i       (sdi_s),
    .byte_valid_o(byte_valid),
    .byte_o      (rx_byte)
  );

  spi_cmd_parser #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) i_parser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .byte_valid_i (byte_valid),
    .byte_i       (rx_byte),
    .instr_valid_o(instr_valid_o),
    .instr_op_o   (instr_op_o),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o)
  );

  spi_tx_shifter #(.DATA_W(DATA_W)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .fall_i   (fall),
    .rd_req_i (rd_req_o),
    .rd_data_i(rd_data_i),
    .sdo_o    (sdo_o)
  );

endmodule

// File: tb/test_spi_cmd_decoder.sv
`timescale 1ns/1ps
module test_spi_cmd_decoder;

  localparam int HALF = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo;
  logic        instr_valid, wr_valid, rd_req;
  logic [7:0]  instr_op;
  logic [4:0]  wr_addr, rd_addr, rd_addr_q = '0;
  logic [23:0] wr_data, rd_data;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] exp_q[$];   // {kind[1:0], pad[0], addr[4:0], data[23:0]}
  string       tag_q[$];

  always #5 clk = ~clk;

  spi_cmd_decoder i_spi_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .instr_valid_o(instr_valid), .instr_op_o(instr_op),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [23:0] reg_val(input logic [4:0] a);
    return {3'b101, a, ~a, 3'b010, a, 3'b110};
  endfunction

  // register file model: one-cycle read latency
  always @(posedge clk) if (rd_req) rd_addr_q <= rd_addr;
  assign rd_data = reg_val(rd_addr_q);

  task automatic push(input logic [1:0] kind, input logic [4:0] a,
                      input logic [23:0] d, input string tag);
    exp_q.push_back({kind, 1'b0, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic score(input logic [1:0] kind, input logic [4:0] a, input logic [23:0] d);
    logic [31:0] act, e;
    string t;
    act = {kind, 1'b0, a, d};
    compared++;
    if (exp_q.size() == 0) begin
      mismatched++;
      $display("FAIL unexpected strobe: actual %h expected none", act);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (act !== e) begin
        mismatched++;
        $display("FAIL %s strobe: actual %h expected %h", t, act, e);
      end
    end
  endtask

  // monitor: 0 = instruction, 1 = write, 2 = read
  always @(negedge clk) if (rst_n) begin
    if (instr_valid) score(2'd0, 5'd0, {16'd0, instr_op});
    if (wr_valid)    score(2'd1, wr_addr, wr_data);
    if (rd_req)      score(2'd2, rd_addr, 24'd0);
  end

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      #HALF sclk = 1'b1;
      got[i] = sdo;
      #HALF sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] exp_sdo, input string tag);
    logic [7:0] got;
    xfer(b, got);
    compared++;
    if (got !== exp_sdo) begin
      mismatched++;
      $display("FAIL %s sdo byte: actual %h expected %h", tag, got, exp_sdo);
    end
  endtask

  task automatic cs_on();  cs_n = 1'b0; #100; endtask
  task automatic cs_off(); #100 cs_n = 1'b1; #100; endtask

  initial begin : watchdog
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    logic [23:0] d;
    #33 rst_n = 1'b1;
    #50;
    // reset state
    compared++;
    if (sdo !== 1'b0 || instr_valid || wr_valid || rd_req) begin
      mismatched++;
      $display("FAIL R5 reset: actual sdo=%b strobes=%b%b%b expected 0", sdo,
               instr_valid, wr_valid, rd_req);
    end

    cs_on();
    // R4 R5 R7: read of addr 3, filler bytes bring out the value, then zeros
    d = reg_val(5'd3);
    push(2'd2, 5'd3, 24'd0, "R4");
    send(8'h06, 8'h00, "R5 idle");
    send(8'hFF, d[23:16], "R5 R7");
    send(8'hFE, d[15:8],  "R5 R7");
    send(8'hFF, d[7:0],   "R5");
    send(8'hFE, 8'h00,    "R5 after end");

    // R2: instruction in the middle of a read
    d = reg_val(5'd4);
    push(2'd2, 5'd4, 24'd0, "R4");
    send(8'h08, 8'h00, "R4");
    push(2'd0, 5'd0, 24'h00009C, "R2");
    send(8'h9C, d[23:16], "R2");
    send(8'hFF, d[15:8],  "R2");
    // R10: ignored byte does not disturb read
    send(8'h03, d[7:0],   "R10");

    // R8: new read aborts current read
    push(2'd2, 5'd5, 24'd0, "R8");
    send(8'h0A, 8'h00, "R8");
    d = reg_val(5'd5);
    push(2'd2, 5'd7, 24'd0, "R8");
    send(8'h0E, d[23:16], "R8 old");
    d = reg_val(5'd7);
    send(8'hFE, d[23:16], "R8 new");
    send(8'hFE, d[15:8],  "R8 new");
    send(8'hFE, d[7:0],   "R8 new");

    // R3 R11: write with filler-valued and instruction-valued data
    send(8'h52, 8'h00, "R3");
    send(8'hFF, 8'h00, "R11");
    send(8'hFE, 8'h00, "R11");
    push(2'd1, 5'd9, 24'hFFFE9A, "R3 R11");
    send(8'h9A, 8'h00, "R3");
    push(2'd1, 5'd31, 24'h123456, "R3");
    send(8'h7E, 8'h00, "R3");
    send(8'h12, 8'h00, "R3");
    send(8'h34, 8'h00, "R3");
    send(8'h56, 8'h00, "R3");
    cs_off();

    // R9: abandoned write, partial byte, read cut by chip select
    cs_on();
    send(8'h52, 8'h00, "R9");
    send(8'h11, 8'h00, "R9");
    cs_off();
    cs_on();
    push(2'd0, 5'd0, 24'h00009D, "R9 write abandoned");
    send(8'h9D, 8'h00, "R9");
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1;
      #HALF sclk = 1'b1;
      #HALF sclk = 1'b0;
    end
    cs_off();
    cs_on();
    push(2'd0, 5'd0, 24'h0000A1, "R9 partial byte");
    send(8'hA1, 8'h00, "R1 R9");
    d = reg_val(5'd2);
    push(2'd2, 5'd2, 24'd0, "R4");
    send(8'h04, 8'h00, "R4");
    send(8'hFF, d[23:16], "R5");
    cs_off();
    compared++;
    if (sdo !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 sdo after release: actual %b expected 0", sdo);
    end
    cs_on();
    send(8'hFF, 8'h00, "R9 read stopped");
    cs_off();

    #500;
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R12 missing strobes: actual %0d pending expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule